// File: doc/BRIEF.md
# Cross-Cluster Memory Access Sequencer

This block sits between the two clusters of a clustered processor and the two halves of its split first-level data cache. Each cluster owns one cache module, and every program variable lives in exactly one of them: one address bit selects the space, and with it the module. A memory operation that a cluster issues against its own space goes straight to its own module. It takes no stall and puts nothing on the shared inter-cluster bus.

An operation that targets the other cluster's space is not an error. It only costs time. The sequencer accepts it and stalls both clusters. It then waits until the shared bus reports no traffic and sends the request across. It accesses the remote module, carries the reply back and releases the clusters. A remote load delivers its data to the issuing cluster alone, marked by a one-cycle valid pulse in the cycle the stall drops. Only one remote operation runs at a time. When both clusters mis-issue in the same cycle, cluster 0 goes first and cluster 1 follows without the stall being released in between.

Both cache modules are modelled as synchronous memories. Read data appears one cycle after the enable.

Top module: `xcl_mem_seq`

## Requirements
- R1: A request from a cluster whose space bit equals the cluster index, issued while that cluster's stall is low, enables the cluster's own module in the same cycle. It raises no stall and no `bus_req`. A read returns the module's data with `cN_rvalid` high in the following cycle.
- R2: Address bit `SPACE_BIT` (default the most significant bit) selects the module: the value 0 selects module 0 and the value 1 selects module 1. A request is remote when that bit differs from the issuing cluster's index (cluster 0 = 0, cluster 1 = 1).
- R3: A remote request accepted in cycle t drives both stall outputs high from cycle t+1. On an idle bus, `bus_req` is high in t+2, the remote module is enabled in t+3 with the captured address, write flag and data, and `bus_req` is high in t+4. Both stalls are low again in t+5. The stall therefore lasts four cycles.
- R4: While `bus_busy` is high, the sequencer waits before sending. Each cycle of waiting lengthens the stall by one cycle, and during the wait it raises neither `bus_req` nor any module enable.
- R5: For a remote load, the requesting cluster alone sees `rvalid` high with the remote module's data in the cycle after the reply. The other cluster's `rvalid` stays low in that cycle.
- R6: A remote store writes its data into the remote module and produces no `rvalid` pulse.
- R7: Requests that arrive while the stalls are high are ignored: they enable no module and change no stored data.
- R8: When both clusters issue remote requests in the same cycle, cluster 0 is served first. Cluster 0's `rvalid` pulses in t+5 while both stalls stay high. Cluster 1 is then served: its `rvalid` pulses in t+10 and both stalls drop in that cycle.
- R9: After reset, both stall outputs, `bus_req`, both module enables and both `rvalid` outputs are low.
- R10: A local request from one cluster in the same cycle that the other cluster issues a remote request completes as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Cluster 0 memory request |
| c0_we | input | 1 | Cluster 0 write flag (1 = store) |
| c0_addr | input | ADDR_W | Cluster 0 address |
| c0_wdata | input | DATA_W | Cluster 0 store data |
| c0_stall | output | 1 | Stall to cluster 0 |
| c0_rvalid | output | 1 | Load data valid for cluster 0 |
| c0_rdata | output | DATA_W | Load data for cluster 0 |
| c1_req | input | 1 | Cluster 1 memory request |
| c1_we | input | 1 | Cluster 1 write flag |
| c1_addr | input | ADDR_W | Cluster 1 address |
| c1_wdata | input | DATA_W | Cluster 1 store data |
| c1_stall | output | 1 | Stall to cluster 1 |
| c1_rvalid | output | 1 | Load data valid for cluster 1 |
| c1_rdata | output | DATA_W | Load data for cluster 1 |
| bus_busy | input | 1 | Shared inter-cluster bus carries traffic |
| bus_req | output | 1 | Sequencer drives the bus (request or reply leg) |
| m0_en | output | 1 | Module 0 enable |
| m0_we | output | 1 | Module 0 write enable |
| m0_addr | output | ADDR_W | Module 0 address |
| m0_wdata | output | DATA_W | Module 0 write data |
| m0_rdata | input | DATA_W | Module 0 read data, one cycle after enable |
| m1_en | output | 1 | Module 1 enable |
| m1_we | output | 1 | Module 1 write enable |
| m1_addr | output | ADDR_W | Module 1 address |
| m1_wdata | output | DATA_W | Module 1 write data |
| m1_rdata | input | DATA_W | Module 1 read data, one cycle after enable |

## Verification
The sequencer is driven with local loads from each cluster into its own space, and with remote loads and stores on an idle bus. This separates the direct path from the six-phase sequence by stall length and enable cycle. A remote load issued while the bus stays busy for several cycles shows that the wait is tied to the busy signal rather than to a fixed count. A remote load paired with a same-cycle local load from the other cluster shows that the direct path is not blocked. A same-cycle pair of remote loads shows the service order, and junk stores driven during a stall show that stalled requests leave the memory unchanged.

// File: rtl/xcl_pkg.sv
package xcl_pkg;
    localparam int NUM_CL = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_SEND,
        ST_ACCESS,
        ST_REPLY,
        ST_RESUME
    } seq_state_e;
endpackage

// File: rtl/xcl_route.sv
module xcl_route #(
    parameter int ADDR_W    = 8,
    parameter int SPACE_BIT = ADDR_W - 1,
    parameter int CL_IDX    = 0
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_local,
    output logic              is_remote
);
    localparam logic OWN_SPACE = (CL_IDX != 0);

    logic space_sel;

    always_comb begin
        space_sel = addr[SPACE_BIT];
        is_local  = req && (space_sel == OWN_SPACE);
        is_remote = req && (space_sel != OWN_SPACE);
    end
endmodule

// File: rtl/xcl_seq_fsm.sv
module xcl_seq_fsm
    import xcl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CL-1:0]             rem,
    input  logic [NUM_CL-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_CL-1:0]             we,
    input  logic [NUM_CL-1:0][DATA_W-1:0] wdata,
    input  logic                          bus_busy,
    input  logic [DATA_W-1:0]             remote_rdata,
    output seq_state_e                    state,
    output logic                          accept_ok,
    output logic                          cur_cl,
    output logic [ADDR_W-1:0]             cur_addr,
    output logic                          cur_we,
    output logic [DATA_W-1:0]             cur_wdata,
    output logic [DATA_W-1:0]             reply_data,
    output logic                          reply_pulse,
    output logic                          bus_req
);
    typedef struct packed {
        seq_state_e        st;
        logic              cl;
        logic [ADDR_W-1:0] a;
        logic              w;
        logic [DATA_W-1:0] wd;
        logic              pend;
        logic [ADDR_W-1:0] pa;
        logic              pw;
        logic [DATA_W-1:0] pwd;
        logic [DATA_W-1:0] rd;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        accept_ok = (r_q.st == ST_IDLE) || (r_q.st == ST_RESUME && !r_q.pend);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_DRAIN:  if (!bus_busy) r_d.st = ST_SEND;
            ST_SEND:   r_d.st = ST_ACCESS;
            ST_ACCESS: r_d.st = ST_REPLY;
            ST_REPLY: begin
                r_d.rd = remote_rdata;
                r_d.st = ST_RESUME;
            end
            default: begin
                if (r_q.st == ST_RESUME && r_q.pend) begin
                    r_d.cl   = 1'b1;
                    r_d.a    = r_q.pa;
                    r_d.w    = r_q.pw;
                    r_d.wd   = r_q.pwd;
                    r_d.pend = 1'b0;
                    r_d.st   = ST_DRAIN;
                end else if (rem[0]) begin
                    r_d.cl = 1'b0;
                    r_d.a  = addr[0];
                    r_d.w  = we[0];
                    r_d.wd = wdata[0];
                    r_d.st = ST_DRAIN;
                    if (rem[1]) begin
                        r_d.pend = 1'b1;
                        r_d.pa   = addr[1];
                        r_d.pw   = we[1];
                        r_d.pwd  = wdata[1];
                    end
                end else if (rem[1]) begin
                    r_d.cl = 1'b1;
                    r_d.a  = addr[1];
                    r_d.w  = we[1];
                    r_d.wd = wdata[1];
                    r_d.st = ST_DRAIN;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        state       = r_q.st;
        cur_cl      = r_q.cl;
        cur_addr    = r_q.a;
        cur_we      = r_q.w;
        cur_wdata   = r_q.wd;
        reply_data  = r_q.rd;
        reply_pulse = (r_q.st == ST_RESUME) && !r_q.w;
        bus_req     = (r_q.st == ST_SEND) || (r_q.st == ST_REPLY);
    end
endmodule

// File: rtl/xcl_port_mux.sv
module xcl_port_mux
    import xcl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CL-1:0]             loc_go,
    input  logic [NUM_CL-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_CL-1:0]             we,
    input  logic [NUM_CL-1:0][DATA_W-1:0] wdata,
    input  seq_state_e                    state,
    input  logic                          cur_cl,
    input  logic [ADDR_W-1:0]             cur_addr,
    input  logic                          cur_we,
    input  logic [DATA_W-1:0]             cur_wdata,
    input  logic [DATA_W-1:0]             reply_data,
    input  logic                          reply_pulse,
    input  logic [NUM_CL-1:0][DATA_W-1:0] m_rdata,
    output logic [NUM_CL-1:0]             m_en,
    output logic [NUM_CL-1:0]             m_we,
    output logic [NUM_CL-1:0][ADDR_W-1:0] m_addr,
    output logic [NUM_CL-1:0][DATA_W-1:0] m_wdata,
    output logic [NUM_CL-1:0]             c_rvalid,
    output logic [NUM_CL-1:0][DATA_W-1:0] c_rdata,
    output logic [DATA_W-1:0]             remote_rdata
);
    typedef struct packed {
        logic [NUM_CL-1:0] lrd;
    } mux_t;

    mux_t r_d, r_q;

    always_comb begin
        remote_rdata = m_rdata[~cur_cl];
    end

    for (genvar k = 0; k < NUM_CL; k++) begin : g_mod
        localparam logic IDX = (k != 0);
        logic rem_hit;

        always_comb begin
            rem_hit = (state == ST_ACCESS) && (cur_cl != IDX);
            m_en[k]    = loc_go[k] || rem_hit;
            m_we[k]    = rem_hit ? cur_we    : (loc_go[k] && we[k]);
            m_addr[k]  = rem_hit ? cur_addr  : addr[k];
            m_wdata[k] = rem_hit ? cur_wdata : wdata[k];
        end

        always_comb begin
            r_d.lrd[k]  = loc_go[k] && !we[k];
            c_rvalid[k] = r_q.lrd[k] || (reply_pulse && cur_cl == IDX);
            c_rdata[k]  = (reply_pulse && cur_cl == IDX) ? reply_data : m_rdata[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/xcl_mem_seq.sv
module xcl_mem_seq
    import xcl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SPACE_BIT = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req,
    input  logic              c0_we,
    input  logic [ADDR_W-1:0] c0_addr,
    input  logic [DATA_W-1:0] c0_wdata,
    output logic              c0_stall,
    output logic              c0_rvalid,
    output logic [DATA_W-1:0] c0_rdata,
    input  logic              c1_req,
    input  logic              c1_we,
    input  logic [ADDR_W-1:0] c1_addr,
    input  logic [DATA_W-1:0] c1_wdata,
    output logic              c1_stall,
    output logic              c1_rvalid,
    output logic [DATA_W-1:0] c1_rdata,
    input  logic              bus_busy,
    output logic              bus_req,
    output logic              m0_en,
    output logic              m0_we,
    output logic [ADDR_W-1:0] m0_addr,
    output logic [DATA_W-1:0] m0_wdata,
    input  logic [DATA_W-1:0] m0_rdata,
    output logic              m1_en,
    output logic              m1_we,
    output logic [ADDR_W-1:0] m1_addr,
    output logic [DATA_W-1:0] m1_wdata,
    input  logic [DATA_W-1:0] m1_rdata
);
    logic [NUM_CL-1:0]             req, we, is_loc, is_rem, loc_go;
    logic [NUM_CL-1:0][ADDR_W-1:0] addr;
    logic [NUM_CL-1:0][DATA_W-1:0] wdata;
    logic [NUM_CL-1:0]             m_en, m_we, c_rvalid;
    logic [NUM_CL-1:0][ADDR_W-1:0] m_addr;
    logic [NUM_CL-1:0][DATA_W-1:0] m_wdata, m_rdata, c_rdata;

    seq_state_e        state;
    logic              accept_ok, cur_cl, cur_we, reply_pulse;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata, reply_data, remote_rdata;

    always_comb begin
        req     = {c1_req, c0_req};
        we      = {c1_we, c0_we};
        addr    = {c1_addr, c0_addr};
        wdata   = {c1_wdata, c0_wdata};
        m_rdata = {m1_rdata, m0_rdata};
        loc_go  = is_loc & {NUM_CL{accept_ok}};
    end

    for (genvar k = 0; k < NUM_CL; k++) begin : g_route
        xcl_route #(
            .ADDR_W   (ADDR_W),
            .SPACE_BIT(SPACE_BIT),
            .CL_IDX   (k)
        ) u_route (
            .req      (req[k]),
            .addr     (addr[k]),
            .is_local (is_loc[k]),
            .is_remote(is_rem[k])
        );
    end

    xcl_seq_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rem         (is_rem),
        .addr        (addr),
        .we          (we),
        .wdata       (wdata),
        .bus_busy    (bus_busy),
        .remote_rdata(remote_rdata),
        .state       (state),
        .accept_ok   (accept_ok),
        .cur_cl      (cur_cl),
        .cur_addr    (cur_addr),
        .cur_we      (cur_we),
        .cur_wdata   (cur_wdata),
        .reply_data  (reply_data),
        .reply_pulse (reply_pulse),
        .bus_req     (bus_req)
    );

    xcl_port_mux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_go      (loc_go),
        .addr        (addr),
        .we          (we),
        .wdata       (wdata),
        .state       (state),
        .cur_cl      (cur_cl),
        .cur_addr    (cur_addr),
        .cur_we      (cur_we),
        .cur_wdata   (cur_wdata),
        .reply_data  (reply_data),
        .reply_pulse (reply_pulse),
        .m_rdata     (m_rdata),
        .m_en        (m_en),
        .m_we        (m_we),
        .m_addr      (m_addr),
        .m_wdata     (m_wdata),
        .c_rvalid    (c_rvalid),
        .c_rdata     (c_rdata),
        .remote_rdata(remote_rdata)
    );

    always_comb begin
        c0_stall  = !accept_ok;
        c1_stall  = !accept_ok;
        c0_rvalid = c_rvalid[0];
        c1_rvalid = c_rvalid[1];
        c0_rdata  = c_rdata[0];
        c1_rdata  = c_rdata[1];
        m0_en     = m_en[0];
        m1_en     = m_en[1];
        m0_we     = m_we[0];
        m1_we     = m_we[1];
        m0_addr   = m_addr[0];
        m1_addr   = m_addr[1];
        m0_wdata  = m_wdata[0];
        m1_wdata  = m_wdata[1];
    end
endmodule

// File: rtl/xcl_mem_seq_chk.sv
module xcl_mem_seq_chk #(
    parameter int ADDR_W    = 8,
    parameter int SPACE_BIT = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c0_req,
    input logic              c1_req,
    input logic [ADDR_W-1:0] c0_addr,
    input logic              c0_stall,
    input logic              c0_rvalid,
    input logic              c1_rvalid,
    input logic              bus_busy,
    input logic              bus_req,
    input logic              m0_en,
    input logic              m1_en
);
    // R1: a local request with no stall goes straight to module 0
    assert_local_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_req && !c0_addr[SPACE_BIT] && !c0_stall) |-> (m0_en && !bus_req));

    // R3: the stall only starts after a request was presented
    assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c0_stall) |-> $past(c0_req || c1_req));

    // R3: the stall is released only after the reply leg on the bus
    assert_release_after_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c0_stall) |-> $past(bus_req));

    // R4: a busy bus keeps the sequencer waiting without bus traffic
    assert_wait_on_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(c0_stall) && c0_stall && $past(bus_busy) && !$past(bus_req)
         && !$past(m0_en || m1_en)) |-> !bus_req);

    // R5: a remote load reply reaches only one cluster
    assert_single_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_rvalid && $past(c0_stall)) |-> !c1_rvalid);

    // R7: while stalled at most one module is touched
    assert_one_module_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c0_stall |-> !(m0_en && m1_en));
endmodule

bind xcl_mem_seq xcl_mem_seq_chk #(
    .ADDR_W   (ADDR_W),
    .SPACE_BIT(SPACE_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .c0_req   (c0_req),
    .c1_req   (c1_req),
    .c0_addr  (c0_addr),
    .c0_stall (c0_stall),
    .c0_rvalid(c0_rvalid),
    .c1_rvalid(c1_rvalid),
    .bus_busy (bus_busy),
    .bus_req  (bus_req),
    .m0_en    (m0_en),
    .m1_en    (m1_en)
);

// File: tb/test_xcl_mem_seq.sv
module test_xcl_mem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0, bus_busy = 0;
    logic [AW-1:0] c0_addr = '0, c1_addr = '0;
    logic [DW-1:0] c0_wdata = '0, c1_wdata = '0;
    logic c0_stall, c1_stall, c0_rvalid, c1_rvalid, bus_req;
    logic [DW-1:0] c0_rdata, c1_rdata;
    logic m0_en, m0_we, m1_en, m1_we;
    logic [AW-1:0] m0_addr, m1_addr;
    logic [DW-1:0] m0_wdata, m1_wdata;
    logic [DW-1:0] m0_rdata, m1_rdata;
    logic [DW-1:0] mem0 [16];
    logic [DW-1:0] mem1 [16];

    int n_tests = 0;
    int n_fail  = 0;

    // watch results
    int rv_at[2];
    logic [DW-1:0] rv_dat[2];
    int st_cnt, en_at, busy_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                mem0[i] <= 32'hB000 + i;
                mem1[i] <= 32'hA100 + i;
            end
            m0_rdata <= '0;
            m1_rdata <= '0;
        end else begin
            if (m0_en) begin
                if (m0_we) mem0[m0_addr[3:0]] <= m0_wdata;
                m0_rdata <= mem0[m0_addr[3:0]];
            end
            if (m1_en) begin
                if (m1_we) mem1[m1_addr[3:0]] <= m1_wdata;
                m1_rdata <= mem1[m1_addr[3:0]];
            end
        end
    end

    xcl_mem_seq #(.ADDR_W(AW), .DATA_W(DW)) i_xcl_mem_seq (
        .clk(clk), .rst_n(rst_n),
        .c0_req(c0_req), .c0_we(c0_we), .c0_addr(c0_addr), .c0_wdata(c0_wdata),
        .c0_stall(c0_stall), .c0_rvalid(c0_rvalid), .c0_rdata(c0_rdata),
        .c1_req(c1_req), .c1_we(c1_we), .c1_addr(c1_addr), .c1_wdata(c1_wdata),
        .c1_stall(c1_stall), .c1_rvalid(c1_rvalid), .c1_rdata(c1_rdata),
        .bus_busy(bus_busy), .bus_req(bus_req),
        .m0_en(m0_en), .m0_we(m0_we), .m0_addr(m0_addr), .m0_wdata(m0_wdata),
        .m0_rdata(m0_rdata),
        .m1_en(m1_en), .m1_we(m1_we), .m1_addr(m1_addr), .m1_wdata(m1_wdata),
        .m1_rdata(m1_rdata)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int cl, input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        if (cl == 0) begin
            c0_req = 1; c0_we = we; c0_addr = a; c0_wdata = d;
        end else begin
            c1_req = 1; c1_we = we; c1_addr = a; c1_wdata = d;
        end
    endtask

    task automatic clear_req();
        c0_req = 0; c0_we = 0; c1_req = 0; c1_we = 0;
    endtask

    // Called right after requests are driven at a falling edge (cycle 0).
    // Observes cycles 1..n at falling edges.
    task automatic watch(input int n, input int tgt, input int busy_cycles);
        rv_at[0] = -1; rv_at[1] = -1; st_cnt = 0; en_at = -1; busy_viol = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) clear_req();
            if (c0_stall) st_cnt++;
            if (en_at < 0 && ((tgt == 0) ? m0_en : m1_en)) en_at = i;
            if (rv_at[0] < 0 && c0_rvalid) begin rv_at[0] = i; rv_dat[0] = c0_rdata; end
            if (rv_at[1] < 0 && c1_rvalid) begin rv_at[1] = i; rv_dat[1] = c1_rdata; end
            if (i <= busy_cycles && (bus_req || m0_en || m1_en)) busy_viol++;
            if (i == busy_cycles) bus_busy = 0;
        end
    endtask

    task automatic t_reset();
        check("R9", "stall0", c0_stall, 0);
        check("R9", "stall1", c1_stall, 0);
        check("R9", "bus_req", bus_req, 0);
        check("R9", "en", {m0_en, m1_en}, 0);
        check("R9", "rvalid", {c0_rvalid, c1_rvalid}, 0);
    endtask

    task automatic t_local();
        @(negedge clk);
        drive(0, 0, 8'h03, 0);
        #1;
        check("R1", "m0_en same cycle", m0_en, 1);
        check("R1", "no stall", c0_stall, 0);
        check("R1", "no bus_req", bus_req, 0);
        check("R2", "m1 untouched", m1_en, 0);
        @(negedge clk);
        clear_req();
        check("R1", "rvalid next cycle", c0_rvalid, 1);
        check("R1", "data", c0_rdata, 32'hB003);
        drive(1, 0, 8'h82, 0);
        #1;
        check("R2", "c1 upper space to m1", m1_en, 1);
        @(negedge clk);
        clear_req();
        check("R2", "c1 data", c1_rdata, 32'hA102);
        check("R2", "c1 rvalid", c1_rvalid, 1);
    endtask

    task automatic t_remote_read();
        @(negedge clk);
        drive(0, 0, 8'h85, 0);
        watch(8, 1, 0);
        check("R3", "stall length", st_cnt, 4);
        check("R3", "remote enable cycle", en_at, 3);
        check("R5", "rvalid cycle", rv_at[0], 5);
        check("R5", "reply data", rv_dat[0], 32'hA105);
        check("R5", "other cluster rvalid", rv_at[1], -1);
    endtask

    task automatic t_drain();
        @(negedge clk);
        bus_busy = 1;
        drive(1, 0, 8'h07, 0);
        watch(10, 0, 3);
        check("R4", "stall with 3 busy cycles", st_cnt, 6);
        check("R4", "no traffic while busy", busy_viol, 0);
        check("R4", "rvalid cycle", rv_at[1], 7);
        check("R4", "data", rv_dat[1], 32'hB007);
    endtask

    task automatic t_remote_write();
        @(negedge clk);
        drive(1, 1, 8'h09, 32'hDEAD0009);
        watch(8, 0, 0);
        check("R6", "no rvalid c1", rv_at[1], -1);
        check("R6", "remote enable cycle", en_at, 3);
        @(negedge clk);
        drive(0, 0, 8'h09, 0);
        @(negedge clk);
        clear_req();
        check("R6", "readback", c0_rdata, 32'hDEAD0009);
    endtask

    task automatic t_ignore();
        int en_cnt = 0;
        @(negedge clk);
        drive(0, 0, 8'h81, 0);
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1) clear_req();
            if (m1_en) en_cnt++;
            if (i == 2) drive(1, 1, 8'h8A, 32'h0BAD0BAD);
            if (i == 4) clear_req();
        end
        check("R7", "m1 enables during stall", en_cnt, 1);
        @(negedge clk);
        drive(1, 0, 8'h8A, 0);
        @(negedge clk);
        clear_req();
        check("R7", "memory unchanged", c1_rdata, 32'hA10A);
    endtask

    task automatic t_dual();
        logic st5 = 0, st10 = 1;
        @(negedge clk);
        drive(0, 0, 8'h86, 0);
        drive(1, 0, 8'h04, 0);
        rv_at[0] = -1; rv_at[1] = -1;
        for (int i = 1; i <= 13; i++) begin
            @(negedge clk);
            if (i == 1) clear_req();
            if (rv_at[0] < 0 && c0_rvalid) begin rv_at[0] = i; rv_dat[0] = c0_rdata; end
            if (rv_at[1] < 0 && c1_rvalid) begin rv_at[1] = i; rv_dat[1] = c1_rdata; end
            if (i == 5) st5 = c0_stall;
            if (i == 10) st10 = c1_stall;
        end
        check("R8", "c0 first", rv_at[0], 5);
        check("R8", "c0 data", rv_dat[0], 32'hA106);
        check("R8", "stall held between", st5, 1);
        check("R8", "c1 second", rv_at[1], 10);
        check("R8", "c1 data", rv_dat[1], 32'hB004);
        check("R8", "stall drops at end", st10, 0);
    endtask

    task automatic t_mixed();
        logic en_now;
        @(negedge clk);
        drive(0, 0, 8'h8B, 0);
        drive(1, 0, 8'h8C, 0);
        #1;
        en_now = m1_en;
        check("R10", "local m1 enable", en_now, 1);
        @(negedge clk);
        clear_req();
        check("R10", "local rvalid", c1_rvalid, 1);
        check("R10", "local data", c1_rdata, 32'hA10C);
        rv_at[0] = -1;
        for (int i = 2; i <= 8; i++) begin
            @(negedge clk);
            if (rv_at[0] < 0 && c0_rvalid) begin rv_at[0] = i; rv_dat[0] = c0_rdata; end
        end
        check("R10", "remote still completes", rv_at[0], 5);
        check("R10", "remote data", rv_dat[0], 32'hA10B);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_local();
        t_remote_read();
        t_drain();
        t_remote_write();
        t_ignore();
        t_dual();
        t_mixed();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule